// File: doc/BRIEF.md
# Hybrid Background Model Pixel Pipeline

This block keeps a per-position background estimate for a fixed-camera video stream and turns each incoming pixel into a first motion measure. A pixel arrives with its position index, its value in the current frame, its value in the previous frame and the value of a reference background frame. Two tests decide whether the pixel looks stationary:

- A temporal test compares the current pixel with the previous frame.
- A background test compares the current pixel with the reference background.

Each test that passes offers a candidate value. The candidates are averaged with an add and a one-bit shift.

The background stored for that position then moves a small step toward the average. The step size is set by a learning-rate shift, and a closeness threshold gates the move. The block returns the new background value and the absolute distance between the current pixel and that new background.

Background storage is a small on-block register bank indexed by position. Frame buffering, clustering and morphology sit outside the block. One pixel is accepted per clock, and every result leaves the pipeline a fixed number of cycles later with its own valid flag.

Top module: `bg_model_pipe`

## Requirements
- R1: While `rst_ni` is low, `pix_ready_o` and `out_valid_o` are 0 and every bank entry is marked unloaded. From the first clock edge after release, `pix_ready_o` is 1 and stays 1.
- R2: A pixel accepted at clock edge k (`pix_valid_i` and `pix_ready_o` both high) produces exactly one result, with `out_valid_o` high from edge k+2 until edge k+3. `out_valid_o` is 0 in every other cycle, and the pipeline accepts back-to-back pixels.
- R3: The first pixel at a position after reset is stored as that position's background unchanged, and its `motion_o` is 0.
- R4: The temporal candidate is valid when |cur - prev| <= `tau_fd_i`. Its value is the reference pixel `ref_i`.
- R5: The background candidate is valid when |cur - ref| <= `tau_bs_i`. Its value is the current pixel `cur_i`.
- R6: When both candidates are valid, the mean is floor((ref + cur) / 2). When only one is valid, the mean is that candidate's value.
- R7: For a loaded position with at least one valid candidate and |mean - bg_old| <= `tau_upd_i`, the new background is bg_old + floor((mean - bg_old) / 2^RateShift), clamped to 0..255. Otherwise the background holds. The floor applies to negative differences as well.
- R8: When neither candidate is valid, the stored background of a loaded position is unchanged.
- R9: `motion_o` = |cur - bg_new| for the same pixel, where `bg_o` carries bg_new.
- R10: `bg_o` and `motion_o` keep their values in every cycle that carries no result. Input values presented with `pix_valid_i` low change neither the outputs nor the bank.
- R11: Each position keeps its own background. Updating one position leaves every other position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Input pixel present |
| pix_ready_o | output | 1 | Block can accept a pixel |
| pix_addr_i | input | AddrW | Pixel position index into the background bank |
| cur_i | input | 8 | Current-frame pixel |
| prev_i | input | 8 | Previous-frame pixel |
| ref_i | input | 8 | Reference background pixel |
| tau_fd_i | input | 8 | Temporal stationarity threshold |
| tau_bs_i | input | 8 | Background stationarity threshold |
| tau_upd_i | input | 8 | Largest mean-to-background distance that still updates |
| out_valid_o | output | 1 | Result present |
| bg_o | output | 8 | Updated background pixel |
| motion_o | output | 8 | Absolute difference between current pixel and updated background |

## Verification
A pixel accepted at edge k has its background and motion values registered at edge k+2. The streaming walk therefore compares the result for pixel n at the falling edge that follows pixel n+2's acceptance, which is also where pixel n+3 is driven. Single-pixel directed tests wait three falling edges after driving the pixel before they sample.

Results for a position depend on earlier pixels at the same position. The bench replays every accepted pixel into its own per-position model, so each expectation reflects the whole stream in order. Idle and reset phases are checked at falling edges inside those phases, and a later read through a hold pixel exposes any unwanted bank change.

// File: rtl/bgm_pkg.sv
package bgm_pkg;
  parameter int unsigned PixW = 8;

  typedef logic [PixW-1:0] pix_t;

  typedef struct packed {
    logic vld;
    pix_t val;
  } cand_t;

  function automatic pix_t abs_diff(pix_t a, pix_t b);
    logic signed [PixW:0] d;
    d = $signed({1'b0, a}) - $signed({1'b0, b});
    return d[PixW] ? pix_t'(-d) : pix_t'(d);
  endfunction
endpackage

// File: rtl/bgm_cand.sv
module bgm_cand
  import bgm_pkg::*;
(
  input  pix_t  cur_i,
  input  pix_t  prev_i,
  input  pix_t  ref_i,
  input  pix_t  tau_fd_i,
  input  pix_t  tau_bs_i,
  output cand_t fd_o,
  output cand_t bs_o
);
  always_comb begin
    fd_o.vld = abs_diff(cur_i, prev_i) <= tau_fd_i;
    fd_o.val = ref_i;
    bs_o.vld = abs_diff(cur_i, ref_i) <= tau_bs_i;
    bs_o.val = cur_i;
  end
endmodule

// File: rtl/bgm_update.sv
module bgm_update
  import bgm_pkg::*;
#(
  parameter int unsigned RateShift = 10
) (
  input  cand_t fd_i,
  input  cand_t bs_i,
  input  pix_t  bg_old_i,
  input  logic  loaded_i,
  input  pix_t  cur_i,
  input  pix_t  tau_upd_i,
  output pix_t  bg_new_o
);
  localparam int unsigned W = PixW + 2;
  localparam logic signed [W-1:0] MaxPix = W'((1 << PixW) - 1);

  logic [PixW:0]        sum;
  pix_t                 mean;
  logic                 any_vld;
  logic signed [W-1:0]  diff, step, nxt;

  always_comb begin
    sum     = {1'b0, fd_i.val} + {1'b0, bs_i.val};
    any_vld = fd_i.vld | bs_i.vld;
    unique case ({fd_i.vld, bs_i.vld})
      2'b11:   mean = sum[PixW:1];  // shift-add mean
      2'b10:   mean = fd_i.val;
      default: mean = bs_i.val;
    endcase
    diff = $signed({2'b00, mean}) - $signed({2'b00, bg_old_i});
    step = diff >>> RateShift;
    nxt  = $signed({2'b00, bg_old_i}) + step;
    if (!loaded_i)                                            bg_new_o = cur_i;
    else if (!any_vld || abs_diff(mean, bg_old_i) > tau_upd_i) bg_new_o = bg_old_i;
    else if (nxt < 0)                                         bg_new_o = '0;
    else if (nxt > MaxPix)                                    bg_new_o = '1;
    else                                                      bg_new_o = nxt[PixW-1:0];
  end
endmodule

// File: rtl/bgm_bank.sv
module bgm_bank
  import bgm_pkg::*;
#(
  parameter int unsigned Depth = 16,
  parameter int unsigned AddrW = $clog2(Depth)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AddrW-1:0] rd_addr_i,
  output pix_t             rd_bg_o,
  output logic             rd_loaded_o,
  input  logic             wr_en_i,
  input  logic [AddrW-1:0] wr_addr_i,
  input  pix_t             wr_bg_i
);
  pix_t bg_q [Depth];
  logic ld_q [Depth];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(Depth); i++) begin
        bg_q[i] <= '0;
        ld_q[i] <= 1'b0;
      end
    end else if (wr_en_i) begin
      bg_q[wr_addr_i] <= wr_bg_i;
      ld_q[wr_addr_i] <= 1'b1;
    end
  end

  assign rd_bg_o     = bg_q[rd_addr_i];
  assign rd_loaded_o = ld_q[rd_addr_i];
endmodule

// File: rtl/bg_model_pipe.sv
module bg_model_pipe
  import bgm_pkg::*;
#(
  parameter int unsigned Depth     = 16,
  parameter int unsigned AddrW     = $clog2(Depth),
  parameter int unsigned RateShift = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic [AddrW-1:0] pix_addr_i,
  input  logic [PixW-1:0]  cur_i,
  input  logic [PixW-1:0]  prev_i,
  input  logic [PixW-1:0]  ref_i,
  input  logic [PixW-1:0]  tau_fd_i,
  input  logic [PixW-1:0]  tau_bs_i,
  input  logic [PixW-1:0]  tau_upd_i,
  output logic             out_valid_o,
  output logic [PixW-1:0]  bg_o,
  output logic [PixW-1:0]  motion_o
);
  logic  fire;
  cand_t fd_c, bs_c;

  // stage 1
  logic             s1_vld;
  logic [AddrW-1:0] s1_addr;
  pix_t             s1_cur, s1_tau;
  cand_t            s1_fd, s1_bs;

  // stage 2
  pix_t bg_old, bg_new;
  logic loaded;
  logic s2_vld;
  pix_t s2_cur, s2_bg;

  assign fire = pix_valid_i & pix_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_ready_o <= 1'b0;
    else         pix_ready_o <= 1'b1;
  end

  bgm_cand i_cand (
    .cur_i   (cur_i),
    .prev_i  (prev_i),
    .ref_i   (ref_i),
    .tau_fd_i(tau_fd_i),
    .tau_bs_i(tau_bs_i),
    .fd_o    (fd_c),
    .bs_o    (bs_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_cur  <= '0;
      s1_tau  <= '0;
      s1_fd   <= '0;
      s1_bs   <= '0;
    end else begin
      s1_vld <= fire;
      if (fire) begin
        s1_addr <= pix_addr_i;
        s1_cur  <= cur_i;
        s1_tau  <= tau_upd_i;
        s1_fd   <= fd_c;
        s1_bs   <= bs_c;
      end
    end
  end

  // read and write of the bank sit in the same stage: no forwarding needed
  bgm_bank #(.Depth(Depth), .AddrW(AddrW)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (s1_addr),
    .rd_bg_o    (bg_old),
    .rd_loaded_o(loaded),
    .wr_en_i    (s1_vld),
    .wr_addr_i  (s1_addr),
    .wr_bg_i    (bg_new)
  );

  bgm_update #(.RateShift(RateShift)) i_update (
    .fd_i     (s1_fd),
    .bs_i     (s1_bs),
    .bg_old_i (bg_old),
    .loaded_i (loaded),
    .cur_i    (s1_cur),
    .tau_upd_i(s1_tau),
    .bg_new_o (bg_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      s2_cur <= '0;
      s2_bg  <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_cur <= s1_cur;
        s2_bg  <= bg_new;
      end
    end
  end

  // stage 3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      bg_o        <= '0;
      motion_o    <= '0;
    end else begin
      out_valid_o <= s2_vld;
      if (s2_vld) begin
        bg_o     <= s2_bg;
        motion_o <= abs_diff(s2_cur, s2_bg);
      end
    end
  end
endmodule

// File: rtl/bgm_checker.sv
module bgm_checker
  import bgm_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic pix_valid_i,
  input logic pix_ready_o,
  input pix_t cur_i,
  input logic out_valid_o,
  input pix_t bg_o,
  input pix_t motion_o
);
  logic f1, f2, f3;
  pix_t c1, c2, c3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1 <= 1'b0; f2 <= 1'b0; f3 <= 1'b0;
      c1 <= '0;   c2 <= '0;   c3 <= '0;
    end else begin
      f1 <= pix_valid_i & pix_ready_o;
      f2 <= f1;
      f3 <= f2;
      c1 <= cur_i;
      c2 <= c1;
      c3 <= c2;
    end
  end

  AST_READY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |=> pix_ready_o); // R1
  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == f3); // R2
  AST_MOTION_DIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> motion_o == abs_diff(c3, bg_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !f2 |=> ($stable(bg_o) && $stable(motion_o))); // R10
  AST_OUT_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown({bg_o, motion_o})); // R9
endmodule

bind bg_model_pipe bgm_checker i_bgm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .pix_ready_o(pix_ready_o),
  .cur_i      (cur_i),
  .out_valid_o(out_valid_o),
  .bg_o       (bg_o),
  .motion_o   (motion_o)
);

// File: tb/test_bg_model_pipe.sv
module test_bg_model_pipe;
  localparam int unsigned Depth = 16;
  localparam int unsigned AddrW = 4;
  localparam int unsigned Shift = 1;
  localparam int NVec = 11;

  // {addr, cur, prev, ref, tau_fd, tau_bs, tau_upd}
  localparam logic [55:0] VEC [NVec] = '{
    {8'd0,  8'd100, 8'd0,   8'd0,   8'd0, 8'd0,  8'd0},    // R3 first load
    {8'd1,  8'd50,  8'd0,   8'd0,   8'd0, 8'd0,  8'd0},    // R3
    {8'd0,  8'd110, 8'd108, 8'd90,  8'd5, 8'd10, 8'd50},   // R4 temporal only
    {8'd0,  8'd99,  8'd60,  8'd100, 8'd5, 8'd10, 8'd50},   // R5 background only
    {8'd0,  8'd80,  8'd78,  8'd86,  8'd5, 8'd10, 8'd50},   // R6 both
    {8'd0,  8'd200, 8'd20,  8'd10,  8'd5, 8'd5,  8'd50},   // R8 none
    {8'd0,  8'd85,  8'd85,  8'd20,  8'd0, 8'd0,  8'd5},    // R7 too far
    {8'd1,  8'd255, 8'd255, 8'd255, 8'd0, 8'd0,  8'd255},  // R7 rise
    {8'd1,  8'd0,   8'd255, 8'd0,   8'd0, 8'd0,  8'd255},  // R9
    {8'd1,  8'd3,   8'd3,   8'd0,   8'd0, 8'd5,  8'd255},  // R6 odd sum, negative floor
    {8'd15, 8'd7,   8'd1,   8'd2,   8'd0, 8'd0,  8'd0}     // R11 last position
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pix_valid_i = 1'b0;
  logic             pix_ready_o;
  logic [AddrW-1:0] pix_addr_i = '0;
  logic [7:0]       cur_i = '0, prev_i = '0, ref_i = '0;
  logic [7:0]       tau_fd_i = '0, tau_bs_i = '0, tau_upd_i = '0;
  logic             out_valid_o;
  logic [7:0]       bg_o, motion_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_bg [Depth];
  bit m_ld [Depth];
  int e_bg [NVec];
  int e_mo [NVec];

  always #4 clk = ~clk;

  bg_model_pipe #(.Depth(Depth), .AddrW(AddrW), .RateShift(Shift)) i_bg_model_pipe (
    .clk_i(clk), .rst_ni(rst_ni), .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o),
    .pix_addr_i(pix_addr_i), .cur_i(cur_i), .prev_i(prev_i), .ref_i(ref_i),
    .tau_fd_i(tau_fd_i), .tau_bs_i(tau_bs_i), .tau_upd_i(tau_upd_i),
    .out_valid_o(out_valid_o), .bg_o(bg_o), .motion_o(motion_o)
  );

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int a, input int cur, input int prv, input int rf,
                       input int t1, input int t2, input int t3,
                       output int bg, output int mo);
    int old, mean, d;
    bit fv, bv;
    old = m_bg[a];
    fv = absd(cur, prv) <= t1;
    bv = absd(cur, rf) <= t2;
    if (fv && bv) mean = (rf + cur) / 2;
    else if (fv)  mean = rf;
    else          mean = cur;
    if (!m_ld[a]) bg = cur;
    else if (!(fv || bv) || absd(mean, old) > t3) bg = old;
    else begin
      d  = mean - old;
      bg = old + (d >>> Shift);
      if (bg < 0) bg = 0;
      if (bg > 255) bg = 255;
    end
    m_bg[a] = bg;
    m_ld[a] = 1'b1;
    mo = absd(cur, bg);
  endtask

  task automatic model_reset();
    for (int i = 0; i < int'(Depth); i++) begin
      m_bg[i] = 0;
      m_ld[i] = 1'b0;
    end
  endtask

  task automatic drive(input logic [55:0] v);
    pix_valid_i = 1'b1;
    pix_addr_i  = AddrW'(v[55:48]);
    cur_i = v[47:40]; prev_i = v[39:32]; ref_i = v[31:24];
    tau_fd_i = v[23:16]; tau_bs_i = v[15:8]; tau_upd_i = v[7:0];
  endtask

  task automatic send_one(input logic [55:0] v, input string req);
    int eb, em;
    @(negedge clk);
    drive(v);
    model(int'(v[55:48]) % Depth, v[47:40], v[39:32], v[31:24], v[23:16], v[15:8], v[7:0], eb, em);
    @(negedge clk);
    pix_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " out_valid"}, out_valid_o, 1);
    check({req, " bg"}, bg_o, eb);
    check({req, " motion"}, motion_o, em);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hb, hm;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 ready in reset", pix_ready_o, 0);
    check("R1 out_valid in reset", out_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", pix_ready_o, 1);

    // streaming walk: result of pixel n is due at the falling edge where pixel n+3 is driven (R2)
    for (int s = 0; s < NVec + 3; s++) begin
      if (s >= 3) begin
        check("R2 out_valid stream", out_valid_o, 1);
        check("R7 bg stream", bg_o, e_bg[s-3]);
        check("R9 motion stream", motion_o, e_mo[s-3]);
      end else begin
        check("R2 no early result", out_valid_o, 0);
      end
      if (s < NVec) begin
        drive(VEC[s]);
        model(int'(VEC[s][55:48]) % Depth, VEC[s][47:40], VEC[s][39:32], VEC[s][31:24],
              VEC[s][23:16], VEC[s][15:8], VEC[s][7:0], e_bg[s], e_mo[s]);
      end else begin
        pix_valid_i = 1'b0;
      end
      @(negedge clk);
    end
    check("R2 single pulse", out_valid_o, 0);

    // R10: garbage with valid low changes nothing
    hb = bg_o;
    hm = motion_o;
    cur_i = 8'd33; prev_i = 8'd33; ref_i = 8'd33;
    tau_fd_i = 8'hFF; tau_bs_i = 8'hFF; tau_upd_i = 8'hFF; pix_addr_i = '0;
    repeat (4) @(negedge clk);
    check("R10 out_valid idle", out_valid_o, 0);
    check("R10 bg held", bg_o, hb);
    check("R10 motion held", motion_o, hm);

    // R8/R10: hold pixel reads back position 0 untouched
    send_one({8'd0, 8'd200, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255}, "R8 hold readback");
    // R11: position 1 kept its own value
    send_one({8'd1, 8'd250, 8'd0, 8'd0, 8'd0, 8'd0, 8'd255}, "R11 position 1");

    // R1/R3: reset mid-run, then first pixel loads directly
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 ready in second reset", pix_ready_o, 0);
    check("R1 out_valid in second reset", out_valid_o, 0);
    rst_ni = 1'b1;
    send_one({8'd0, 8'd42, 8'd0, 8'd255, 8'd0, 8'd0, 8'd0}, "R3 reload after reset");
    check("R3 motion zero", motion_o, 0);

    finish_run();
  end
endmodule